// File: doc/BRIEF.md
# Streaming Hamming ECC Generator

This block sits beside the byte path of a NAND flash controller and builds a single-error-correcting Hamming code over the data as it streams past. It does not stall or buffer the stream. Each accepted byte updates a running parity state. After every 256 accepted bytes the finished code is copied into a holding register, a one-cycle done pulse is raised, and the running state starts the next step from zero. Each code covers one 256-byte step whatever the page size, and it can locate at most one flipped bit in that step.

The code word keeps column parity in its low six bits and line parity in the sixteen bits above them. A formatter turns the held code into the three bytes that go into the spare area: the code shifted left by two, inverted over 24 bits, with the first byte to write at the top. A 512-byte page therefore takes six spare bytes. A clear input drops any partly built step before a new transfer starts.

Top module: `hamming_stream_ecc`

## Requirements
- R1: While reset is held, and after it, `ecc_word` is 0, `step_done` is 0 and `spare_code` is 24'hFFFFFF.
- R2: A code is completed after exactly 256 accepted bytes. `step_done` is high for exactly the one cycle after the clock edge that accepts the 256th byte, and `ecc_word` carries the new code in that same cycle.
- R3: Column parity sits in `ecc_word[5:0]`. For position bit k (0..2), bit 2k is the XOR of all data bits in the step whose bit position has bit k clear, and bit 2k+1 is the XOR of those whose position has bit k set.
- R4: Line parity sits in `ecc_word[21:6]`. For index bit k (0..7) of the byte's index within its step, bit 6+2k is the XOR of the parities of the bytes whose index has bit k clear, and bit 7+2k is the XOR for the bytes whose index has bit k set.
- R5: `ecc_word` changes only in a `step_done` cycle. It holds the last finished code for as long as the stream is idle, so the final step of a transfer can be read after the stream ends.
- R6: A byte accepted in the cycle right after a step's 256th byte becomes index 0 of the next step. The next step starts from all-zero parity and loses no cycle.
- R7: A cycle with `clear` high and `in_valid` low throws away the partial step: both the byte count and the parity state return to zero. `ecc_word` is left unchanged.
- R8: When `clear` and `in_valid` are high in the same cycle, the partial step is discarded first and that byte becomes index 0 of a fresh step.
- R9: `spare_code` equals ~{ecc_word, 2'b00} over 24 bits. Bits [23:16] are the first spare byte to write, then [15:8], then [7:0].
- R10: A cycle with `in_valid` low has no effect on the code or on the byte count, whatever value `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Discard the partial step and restart counting |
| in_valid | input | 1 | `in_byte` is accepted at this clock edge |
| in_byte | input | 8 | Data byte from the NAND data path |
| ecc_word | output | 22 | Held code of the last completed step |
| step_done | output | 1 | One-cycle pulse: `ecc_word` has just been updated |
| spare_code | output | 24 | Stored form of `ecc_word`, first byte to write in [23:16] |

## Verification
Two functions can land in one cycle. The first is the completion of a step together with the first byte of the next step: the 256th byte and the byte after it arrive back to back. The second is a clear together with an accepted byte. The bench drives random streams with random idle gaps and with no gaps at step boundaries. It also issues a clear, with and without a valid byte, part-way through a step. A reference model that knows only the requirements tracks the byte index and the parity of every step. At every cycle the bench compares `step_done`, `ecc_word` and `spare_code` against that model.

// File: rtl/hse_pkg.sv
// Package: shared constants for the streaming Hamming ECC generator.
// Assumes byte-wide data; every size the modules use derives from these.
package hse_pkg;
    localparam int BYTE_W        = 8;
    localparam int POS_W         = $clog2(BYTE_W);
    localparam int DEF_STEP      = 256;
    localparam int SHIFT_PAD     = 2;
endpackage

// File: rtl/hse_step_counter.sv
// Module: hse_step_counter
// Counts accepted bytes within a step and reports the index of the byte
// being accepted now, after a clear has been applied. Raises wrap when that
// byte is the last one of a step. Assumes STEP_BYTES is a power of two.
module hse_step_counter #(
    parameter int STEP_BYTES = hse_pkg::DEF_STEP,
    localparam int IDX_W     = $clog2(STEP_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    output logic [IDX_W-1:0] idx_now,
    output logic             wrap
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEP_BYTES - 1);

    logic [IDX_W-1:0] idx_q;

    // Effective index of the incoming byte: a clear restarts at zero.
    always_comb begin
        idx_now = clear ? '0 : idx_q;
        wrap    = take && (idx_now == LAST_IDX);
    end

    // Advance the index on each accepted byte, wrapping at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (wrap)
            idx_q <= '0;
        else if (take)
            idx_q <= idx_now + IDX_W'(1);
        else
            idx_q <= idx_now;
    end
endmodule

// File: rtl/hse_parity_accum.sv
// Module: hse_parity_accum
// Keeps the running parity of one step: an XOR of all bytes (folded into
// column parity at the end) and one even/odd line-parity pair per index bit.
// code_next is the full code including the byte being accepted now; the
// running state returns to zero when the step wraps. Assumes idx_now and
// wrap come from the step counter in the same cycle.
module hse_parity_accum #(
    parameter int STEP_BYTES = hse_pkg::DEF_STEP,
    localparam int IDX_W     = $clog2(STEP_BYTES),
    localparam int BW        = hse_pkg::BYTE_W,
    localparam int PW        = hse_pkg::POS_W,
    localparam int CODE_W    = 2 * IDX_W + 2 * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              wrap,
    input  logic [IDX_W-1:0]  idx_now,
    input  logic [BW-1:0]     data,
    output logic [CODE_W-1:0] code_next
);
    logic [BW-1:0]    col_q, col_base, col_add;
    logic [IDX_W-1:0] lev_q, lod_q, lev_base, lod_base, lev_add, lod_add;
    logic             byte_par;
    logic [2*PW-1:0]  col_code;

    // Fold the incoming byte into a copy of the state (cleared if asked).
    always_comb begin
        col_base = clear ? '0 : col_q;
        lev_base = clear ? '0 : lev_q;
        lod_base = clear ? '0 : lod_q;
        byte_par = ^data;
        col_add  = col_base ^ data;
        lev_add  = lev_base ^ ({IDX_W{byte_par}} & ~idx_now);
        lod_add  = lod_base ^ ({IDX_W{byte_par}} &  idx_now);
    end

    // Column parity: split the byte-wise XOR by each position-index bit.
    always_comb begin
        col_code = '0;
        for (int k = 0; k < PW; k++) begin
            for (int b = 0; b < BW; b++) begin
                if (((b >> k) & 1) != 0)
                    col_code[2*k+1] = col_code[2*k+1] ^ col_add[b];
                else
                    col_code[2*k]   = col_code[2*k]   ^ col_add[b];
            end
        end
    end

    // Interleave line-parity pairs above the column bits.
    generate
        for (genvar k = 0; k < IDX_W; k++) begin : g_line
            assign code_next[2*PW + 2*k]     = lev_add[k];
            assign code_next[2*PW + 2*k + 1] = lod_add[k];
        end
    endgenerate
    assign code_next[2*PW-1:0] = col_code;

    // Register the running state; a wrap starts the next step at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            col_q <= '0;
            lev_q <= '0;
            lod_q <= '0;
        end else if (take) begin
            col_q <= col_add;
            lev_q <= lev_add;
            lod_q <= lod_add;
        end else begin
            col_q <= col_base;
            lev_q <= lev_base;
            lod_q <= lod_base;
        end
    end
endmodule

// File: rtl/hse_spare_format.sv
// Module: hse_spare_format
// Converts a held code into its stored spare-area form: the code shifted
// left by two, inverted, and zero-extended to a whole number of bytes. The
// first byte to write is the most significant. Purely combinational.
module hse_spare_format #(
    parameter int CODE_W   = 22,
    localparam int SPARE_N = (CODE_W + hse_pkg::SHIFT_PAD + 7) / 8,
    localparam int SPARE_W = 8 * SPARE_N
) (
    input  logic [CODE_W-1:0]  code,
    output logic [SPARE_W-1:0] spare
);
    logic [SPARE_W-1:0] shifted;

    // Shift into byte-aligned width and invert every bit.
    always_comb begin
        shifted = SPARE_W'(code) << hse_pkg::SHIFT_PAD;
        spare   = ~shifted;
    end
endmodule

// File: rtl/hamming_stream_ecc.sv
// Module: hamming_stream_ecc (top)
// Streaming Hamming ECC generator for one 256-byte step at a time. It holds
// the finished code until the next step completes, pulses step_done for one
// cycle when the held code changes, and presents the spare-area form. Assumes
// the data source never needs back-pressure.
module hamming_stream_ecc #(
    parameter int STEP_BYTES = hse_pkg::DEF_STEP,
    localparam int IDX_W     = $clog2(STEP_BYTES),
    localparam int CODE_W    = 2 * IDX_W + 2 * hse_pkg::POS_W,
    localparam int SPARE_W   = 8 * ((CODE_W + hse_pkg::SHIFT_PAD + 7) / 8)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       in_valid,
    input  logic [hse_pkg::BYTE_W-1:0] in_byte,
    output logic [CODE_W-1:0]          ecc_word,
    output logic                       step_done,
    output logic [SPARE_W-1:0]         spare_code
);
    logic [IDX_W-1:0]  idx_now;
    logic              wrap;
    logic [CODE_W-1:0] code_next;
    logic [CODE_W-1:0] hold_q;
    logic              done_q;

    hse_step_counter #(.STEP_BYTES(STEP_BYTES)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .take    (in_valid),
        .idx_now (idx_now),
        .wrap    (wrap)
    );

    hse_parity_accum #(.STEP_BYTES(STEP_BYTES)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .take      (in_valid),
        .wrap      (wrap),
        .idx_now   (idx_now),
        .data      (in_byte),
        .code_next (code_next)
    );

    // Latch the completed code and flag it for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= wrap;
            if (wrap)
                hold_q <= code_next;
        end
    end

    hse_spare_format #(.CODE_W(CODE_W)) u_fmt (
        .code  (hold_q),
        .spare (spare_code)
    );

    assign ecc_word  = hold_q;
    assign step_done = done_q;
endmodule

// File: rtl/hse_checker.sv
// Module: hse_checker
// Temporal checks on the ECC generator ports. Keeps its own count of
// accepted bytes per step, so the step window needs no long $past.
module hse_checker #(
    parameter int STEP_BYTES = 256,
    parameter int CODE_W     = 22,
    localparam int IDX_W     = $clog2(STEP_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              in_valid,
    input logic [CODE_W-1:0] ecc_word,
    input logic              step_done
);
    logic [IDX_W-1:0] seen_cnt;
    logic             armed;

    // Independent byte count per step, and a flag that one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_cnt <= '0;
            armed    <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (clear)
                seen_cnt <= in_valid ? IDX_W'(1) : '0;
            else if (in_valid)
                seen_cnt <= seen_cnt + IDX_W'(1);
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    assert_done_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && step_done) |-> $past(in_valid));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !step_done) |-> $stable(ecc_word));

    // Covers R6, R7 and R8: done lands exactly where the independent count wraps.
    assert_wrap_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (step_done == ($past(in_valid) && !($past(clear) && STEP_BYTES > 1)
                                  && seen_cnt == '0)));
endmodule

bind hamming_stream_ecc hse_checker #(.STEP_BYTES(STEP_BYTES), .CODE_W(CODE_W)) u_hse_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .ecc_word  (ecc_word),
    .step_done (step_done)
);

// File: tb/tb_hamming_stream_ecc.sv
module tb_hamming_stream_ecc;
    localparam int STEP = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [21:0] ecc_word;
    logic        step_done;
    logic [23:0] spare_code;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0]  mem [STEP];
    int          mcnt = 0;
    logic [21:0] exp_hold = '0;

    always #5 clk = ~clk;

    hamming_stream_ecc dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_byte(in_byte), .ecc_word(ecc_word), .step_done(step_done),
        .spare_code(spare_code)
    );

    // Reference code computed bit by bit from the R3/R4 definitions.
    function automatic logic [21:0] ref_code();
        logic [21:0] c = '0;
        for (int i = 0; i < STEP; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    for (int k = 0; k < 3; k++)
                        c[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int k = 0; k < 8; k++)
                        c[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
                end
            end
        end
        return c;
    endfunction

    function automatic logic [23:0] ref_spare(input logic [21:0] c);
        logic [23:0] s = {c, 2'b00};
        return ~s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, accept at posedge, compare at next negedge.
    task automatic cycle(input logic v, input logic [7:0] b, input logic c);
        logic exp_done = 1'b0;
        in_valid = v; in_byte = b; clear = c;
        @(posedge clk);
        @(negedge clk);
        if (c) mcnt = 0;
        if (v) begin
            mem[mcnt] = b;
            mcnt++;
            if (mcnt == STEP) begin
                exp_hold = ref_code();
                mcnt = 0;
                exp_done = 1'b1;
            end
        end
        chk("R2 step_done", 32'(step_done), 32'(exp_done));
        chk("R5 ecc_word", 32'(ecc_word), 32'(exp_hold));
        chk("R9 spare_code", 32'(spare_code), 32'(ref_spare(exp_hold)));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 8'($urandom), 1'b0); // R10 garbage byte ignored
    endtask

    task automatic rand_step(input bit gaps);
        for (int i = 0; i < STEP; i++) begin
            if (gaps && ($urandom % 5 == 0)) idle(1 + $urandom % 3);
            cycle(1'b1, 8'($urandom), 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        chk("R1 reset ecc", 32'(ecc_word), 0);
        chk("R1 reset done", 32'(step_done), 0);
        chk("R1 reset spare", 32'(spare_code), 32'hFFFFFF);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset spare", 32'(spare_code), 32'hFFFFFF);

        // All-zero step gives a zero code (R3, R4).
        for (int i = 0; i < STEP; i++) cycle(1'b1, 8'h00, 1'b0);
        chk("R3 zero step", 32'(ecc_word), 0);

        // Single set bit: byte 0xA5, bit 3 (directed R3/R4/R9 values).
        for (int i = 0; i < STEP; i++) cycle(1'b1, (i == 8'hA5) ? 8'h08 : 8'h00, 1'b0);
        chk("R4 single bit code", 32'(ecc_word), 32'h26599A);
        chk("R9 single bit spare", 32'(spare_code), 32'h669997);

        // Back-to-back random steps without gaps, then with gaps (R6, R10).
        rand_step(0); rand_step(0);
        chk("R6 back-to-back", 32'(ecc_word), 32'(exp_hold));
        rand_step(1); rand_step(1);

        // Clear part-way through a step, no byte (R7).
        for (int i = 0; i < 100; i++) cycle(1'b1, 8'($urandom), 1'b0);
        cycle(1'b0, 8'hFF, 1'b1);
        chk("R7 clear keeps ecc", 32'(ecc_word), 32'(exp_hold));
        rand_step(1);

        // Clear together with a byte (R8).
        for (int i = 0; i < 77; i++) cycle(1'b1, 8'($urandom), 1'b0);
        cycle(1'b1, 8'h5C, 1'b1);
        for (int i = 1; i < STEP; i++) cycle(1'b1, 8'($urandom), 1'b0);
        chk("R8 clear with byte", 32'(ecc_word), 32'(exp_hold));

        // Final step remains readable after the stream stops (R5).
        idle(60);
        chk("R5 final held", 32'(ecc_word), 32'(exp_hold));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule